// File: doc/BRIEF.md
# MDIO Management Master

This block lets software on a register bus run single management transactions (one register read or one register write) against an external Ethernet PHY over the two-wire MDIO interface. Software first sets the clock divisor and the enable bit in the configuration word. For a write it loads the data word. It then writes the control word with the PHY address, the register address, the operation and the initiate bit. The block generates MDC and shifts out the complete 64-bit frame. It releases the data line while the PHY answers a read, and it drops its ready flag until the frame ends.

MDC runs only while a transaction is in flight and rests low between transactions. Output data changes right after MDC falls. Input data is sampled as MDC rises. A read result is loaded into the read-data word when the frame completes. If no PHY answers, the pulled-up line reads back as all ones.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the configuration word reads divisor 29 with the enable (bit 6) clear, the control word reads only the ready flag (bit 7) set, and MDC and the output-enable are low.
- R2: Word offsets: 0x0 configuration (divisor in bits 5:0, enable in bit 6), 0x4 control (PHY address 28:24, register address 20:16, read op bit 15, write op bit 14, initiate bit 11, ready bit 7), 0x8 write data (bits 15:0), 0xC read data (bits 15:0). Reads return data one cycle after the address is presented.
- R3: The initiate bit always reads back 0. Ready reads 0 from the cycle after an accepted initiate until the frame has ended, then reads 1 again.
- R4: While a frame runs, MDC has a period of 2*(divisor+1) clocks, using the divisor that was in force when the frame started. MDC is low whenever no frame is running.
- R5: A write frame is sent MSB first with output-enable high for all 64 bits: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 write-data bits. The output changes only after a falling MDC edge.
- R6: A read frame drives 32 ones, start 01, opcode 10, the PHY address and the register address (46 bits). Output-enable is low for the remaining 18 bits. The 16 data bits are sampled on the rising MDC edges and appear in the read-data word once ready returns.
- R7: A read from a PHY that never drives the line (input held high) leaves 0xFFFF in the read-data word.
- R8: An initiate written while the enable bit is clear starts no frame: MDC stays low and ready stays 1.
- R9: A control write while a frame is in progress is ignored. The stored address fields do not change and no second frame follows.
- R10: An initiate whose operation bits 15:14 are both set or both clear starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output-enable |
| mdio_i | input | 1 | Management data in |

## Verification
A table of reads and writes drives the main path with varied PHY addresses, register addresses and data words, including all-zero and all-one fields and alternating patterns. These patterns show whether any address or data bit is swapped, shifted or stuck. The table mixes several divisors, so the measured MDC period shows whether the divisor is applied, and the captured frames show whether read and write opcodes, turnarounds and output-enable release are distinguished. Directed cases then cover initiate while disabled, initiate with an invalid opcode, a control write in mid-frame, a silent PHY, and the reset divisor.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;  // first bit after the address fields
  localparam int DATA_IDX   = 48;  // first data bit
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int WORD_W     = 16;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              is_rd,
    input logic [PHY_W-1:0]  phy,
    input logic [REG_W-1:0]  regad,
    input logic [WORD_W-1:0] wdata
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [WORD_W-1:0] dat;
    op  = is_rd ? 2'b10 : 2'b01;
    ta  = is_rd ? 2'b11 : 2'b10;
    dat = is_rd ? {WORD_W{1'b1}} : wdata;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  always_comb begin
    tick     = run && (cnt == div);
    rise_stb = tick && !mdc;
    fall_stb = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= div)) else $error("divider count overran");  // R4
  AST_MDC_PARKED: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc) else $error("mdc toggled while idle");  // R4
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_rd,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regad,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [WORD_W-1:0] rdata
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  rd_mode;
  logic [IDX_W:0]        nxt_idx;

  assign nxt_idx = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      rd_mode <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        rd_mode <= is_rd;
        idx     <= '0;
        sh      <= build_frame(is_rd, phy, regad, wdata) << 1;
        mdio_o  <= build_frame(is_rd, phy, regad, wdata) >> (FRAME_BITS - 1);
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise_stb && rd_mode && (int'(idx) >= DATA_IDX))
          rdata <= {rdata[WORD_W-2:0], mdio_i};
        if (fall_stb) begin
          if (int'(idx) == FRAME_BITS - 1) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
          end else begin
            idx     <= nxt_idx[IDX_W-1:0];
            mdio_o  <= sh[FRAME_BITS-1];
            sh      <= sh << 1;
            mdio_oe <= !(rd_mode && (int'(nxt_idx) >= TA_IDX));
          end
        end
      end
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_mode && (int'(idx) >= TA_IDX)) |-> !mdio_oe) else $error("line driven during read reply");  // R6
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_mode) |-> mdio_oe) else $error("write frame not driven");  // R5
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(fall_stb)) |-> $stable(mdio_o)) else $error("data moved off falling edge");  // R5
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFF_WD   = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFF_RD   = ADDR_W'(4'hC);
  localparam int EN_BIT   = 6;
  localparam int RDY_BIT  = 7;
  localparam int GO_BIT   = 11;
  localparam int OPW_BIT  = 14;
  localparam int OPR_BIT  = 15;
  localparam int REG_LSB  = 16;
  localparam int PHY_LSB  = 24;

  logic [DIV_W-1:0]  div_q, run_div;
  logic              en_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic              opr_q, opw_q;
  logic [WORD_W-1:0] wd_q, rd_q;
  logic              busy, done, rise_stb, fall_stb;
  logic [WORD_W-1:0] eng_rdata;
  logic              ctrl_wr, op_ok, start;
  logic [31:0]       rd_mux;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[31:29], bus_wdata[23:21], bus_wdata[13:12], bus_wdata[10:7]};

  always_comb begin
    ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);
    op_ok   = bus_wdata[OPR_BIT] ^ bus_wdata[OPW_BIT];
    start   = ctrl_wr && !busy && en_q && bus_wdata[GO_BIT] && op_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= DIV_W'(DIV_RST);
      run_div <= DIV_W'(DIV_RST);
      en_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      opr_q   <= 1'b0;
      opw_q   <= 1'b0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      if (bus_wr && bus_addr == OFF_CFG) begin
        div_q <= bus_wdata[DIV_W-1:0];
        en_q  <= bus_wdata[EN_BIT];
      end
      if (bus_wr && bus_addr == OFF_WD)
        wd_q <= bus_wdata[WORD_W-1:0];
      if (ctrl_wr && !busy) begin
        phy_q <= bus_wdata[PHY_LSB +: PHY_W];
        reg_q <= bus_wdata[REG_LSB +: REG_W];
        opr_q <= bus_wdata[OPR_BIT];
        opw_q <= bus_wdata[OPW_BIT];
      end
      if (start)
        run_div <= div_q;
      if (done && opr_q)
        rd_q <= eng_rdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_CFG: begin
        rd_mux[DIV_W-1:0] = div_q;
        rd_mux[EN_BIT]    = en_q;
      end
      OFF_CTRL: begin
        rd_mux[PHY_LSB +: PHY_W] = phy_q;
        rd_mux[REG_LSB +: REG_W] = reg_q;
        rd_mux[OPR_BIT]          = opr_q;
        rd_mux[OPW_BIT]          = opw_q;
        rd_mux[RDY_BIT]          = !busy;
      end
      OFF_WD:  rd_mux[WORD_W-1:0] = wd_q;
      OFF_RD:  rd_mux[WORD_W-1:0] = rd_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(run_div),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .start(start),
    .is_rd(bus_wdata[OPR_BIT]),
    .phy(bus_wdata[PHY_LSB +: PHY_W]),
    .regad(bus_wdata[REG_LSB +: REG_W]),
    .wdata(wd_q),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rdata(eng_rdata)
  );

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(phy_q) && $stable(reg_q))) else $error("fields changed mid-frame");  // R9
  AST_NO_GO_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !busy) |=> !busy) else $error("frame started while disabled");  // R8
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc) else $error("mdc high while idle");  // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(done) |-> $stable(rd_q)) else $error("read word moved without frame end");  // R6
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  // PHY model state, written only by the tasks
  logic        cur_rd = 1'b0;
  logic        phy_on = 1'b1;
  logic [15:0] phy_resp = '0;
  // capture state, written only by the mdc blocks
  logic [5:0]  nbits = '0;
  logic [63:0] cap = '0;
  int          oecnt = 0;
  int          last_rise = 0;
  int          per_last = 0;
  int          rises = 0;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge mdc) begin
    cap       <= {cap[62:0], mdio_o};
    oecnt     <= (nbits == 0) ? int'(mdio_oe) : oecnt + int'(mdio_oe);
    nbits     <= nbits + 1'b1;
    per_last  <= cyc - last_rise;
    last_rise <= cyc;
    rises     <= rises + 1;
  end

  always @(negedge mdc) begin
    if (cur_rd && phy_on && nbits == 6'd47) mdio_i <= 1'b0;
    else if (cur_rd && phy_on && nbits >= 6'd48) mdio_i <= phy_resp[6'd63 - nbits];
    else mdio_i <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input logic r, input logic w, input logic go,
                                            input logic [4:0] phy, input logic [4:0] rg);
    logic [31:0] v = '0;
    v[28:24] = phy; v[20:16] = rg; v[15] = r; v[14] = w; v[11] = go;
    return v;
  endfunction

  task automatic wait_ready(output logic [31:0] first);
    logic [31:0] d;
    rd(4'h4, first);
    d = first;
    for (int i = 0; i < 40000 && !d[7]; i++) rd(4'h4, d);
  endtask

  // R5/R6 table: {is_rd, phy, reg, data, div}
  localparam logic [32:0] VECS [0:5] = '{
    {1'b0, 5'h00, 5'h00, 16'h0000, 6'd1},
    {1'b0, 5'h1F, 5'h1F, 16'hFFFF, 6'd2},
    {1'b0, 5'h15, 5'h0A, 16'hA55A, 6'd0},
    {1'b1, 5'h0A, 5'h15, 16'h5AA5, 6'd1},
    {1'b1, 5'h1F, 5'h01, 16'h8001, 6'd3},
    {1'b1, 5'h03, 5'h1C, 16'h0000, 6'd0}
  };

  initial begin
    logic [31:0] d, first;
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {mdc, mdio_oe}, 0);
    rd(4'h0, d); chk(d == 32'd29, "R1 cfg reset", d, 29);
    rd(4'h4, d); chk(d == 32'h80, "R1 ctrl reset", d, 32'h80);

    for (int k = 0; k < 6; k++) begin
      logic        vr;
      logic [4:0]  vp, vg;
      logic [15:0] vd;
      logic [5:0]  vv;
      {vr, vp, vg, vd, vv} = VECS[k];
      wr(4'h0, {25'd0, 1'b1, vv});
      cur_rd = vr; phy_resp = vd; phy_on = 1'b1;
      if (!vr) wr(4'h8, {16'd0, vd});
      wr(4'h4, ctrl_word(vr, !vr, 1'b1, vp, vg));
      wait_ready(first);
      chk(first[7] == 1'b0, "R3 ready low in frame", first, 0);
      rd(4'h4, d);
      chk(d[7] && !d[11] && d[28:24] == vp && d[20:16] == vg && d[15] == vr && d[14] == !vr,
          "R2 R3 ctrl readback", d, ctrl_word(vr, !vr, 1'b0, vp, vg) | 32'h80);
      chk(per_last == 2 * (int'(vv) + 1), "R4 mdc period", per_last, 2 * (int'(vv) + 1));
      if (!vr) begin
        chk(cap == {32'hFFFF_FFFF, 2'b01, 2'b01, vp, vg, 2'b10, vd}, "R5 write frame",
            cap, {32'hFFFF_FFFF, 2'b01, 2'b01, vp, vg, 2'b10, vd});
        chk(oecnt == 64, "R5 oe whole frame", oecnt, 64);
        rd(4'h8, d); chk(d == {16'd0, vd}, "R2 wdata readback", d, vd);
      end else begin
        chk(cap[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, vp, vg}, "R6 read header",
            cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, vp, vg});
        chk(oecnt == 46, "R6 oe released", oecnt, 46);
        rd(4'hC, d); chk(d == {16'd0, vd}, "R6 read data", d, vd);
      end
    end

    // R7 silent PHY
    wr(4'h0, 32'h41);
    cur_rd = 1'b1; phy_on = 1'b0;
    wr(4'h4, ctrl_word(1, 0, 1, 5'h07, 5'h02));
    wait_ready(first);
    rd(4'hC, d); chk(d == 32'hFFFF, "R7 no phy", d, 32'hFFFF);
    phy_on = 1'b1;

    // R8 initiate while disabled
    wr(4'h0, 32'h01);
    r0 = rises;
    wr(4'h4, ctrl_word(0, 1, 1, 5'h02, 5'h03));
    repeat (30) @(negedge clk);
    rd(4'h4, d);
    chk(d[7] && rises == r0 && mdc == 1'b0, "R8 disabled ignore", {d[7], 32'(rises - r0)}, 64'h1_0000_0000);

    // R10 invalid opcodes
    wr(4'h0, 32'h41);
    r0 = rises;
    wr(4'h4, ctrl_word(1, 1, 1, 5'h04, 5'h05));
    wr(4'h4, ctrl_word(0, 0, 1, 5'h04, 5'h05));
    repeat (30) @(negedge clk);
    rd(4'h4, d);
    chk(d[7] && rises == r0, "R10 bad opcode ignore", {d[7], 32'(rises - r0)}, 64'h1_0000_0000);

    // R9 control write in mid-frame
    cur_rd = 1'b1; phy_resp = 16'h1234;
    r0 = rises;
    wr(4'h4, ctrl_word(1, 0, 1, 5'h11, 5'h12));
    repeat (40) @(negedge clk);
    wr(4'h4, ctrl_word(0, 1, 1, 5'h0E, 5'h0D));
    wait_ready(first);
    repeat (40) @(negedge clk);
    rd(4'h4, d);
    chk(d[28:24] == 5'h11 && d[20:16] == 5'h12 && d[15], "R9 fields held", d, ctrl_word(1, 0, 0, 5'h11, 5'h12));
    chk(rises - r0 == 64, "R9 single frame", rises - r0, 64);
    rd(4'hC, d); chk(d == 32'h1234, "R9 read result intact", d, 32'h1234);

    // R4 reset divisor
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    wr(4'h0, 32'h40 | 32'd29);
    cur_rd = 1'b0;
    wr(4'h8, 32'hC3C3);
    wr(4'h4, ctrl_word(0, 1, 1, 5'h01, 5'h00));
    wait_ready(first);
    chk(per_last == 60, "R4 default divisor period", per_last, 60);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule